// File: doc/BRIEF.md
# Glitch-Free Synchronous Clock Stop Gate

This block sits on one derived output clock and switches it off and on without ever producing a runt pulse. An active-low stop request arrives asynchronously. The gate passes it through a falling-edge synchronizer and changes its internal enable only on falling edges of the source clock, while the clock is low. As a result the output always stops in the low state, and the first high phase after a restart is full width.

One parameter selects the clock group, and the group sets the timing:

| Group | Falling-edge stages on the request path | Minimum enabled time |
|---|---|---|
| CPU-type | three (a two-flop synchronizer plus one retiming stage) | 100 pulses |
| PCI-type | two | 10 pulses |

If a stop request arrives before the minimum enabled time has elapsed, the gate keeps the request pending and acts on it once the minimum has been met. A free-running variant never responds to its stop input. A global active-low power-down input overrides everything: on the first falling edge at which it is seen low, it forces the output low, whatever the stop input is doing.

The gate is controlled by a four-state machine clocked on the falling edge:

- **HALT** is the reset state and the state after any stop. The output is held low. The transition **start** (request released, or the free-running variant) goes to WARM.
- **WARM** is enabled while the minimum-pulse count is still running. On the transition **settle** (minimum met, no stop pending) it goes to RUN. On **late stop** (minimum met, stop pending) it goes to HALT.
- **RUN** is enabled with no restriction. On **stop** (a synchronized request) it goes to HALT.
- **DOWN** is the power-down state. Every state takes the **power-down** transition into DOWN when `pwrdn_n` is low at a falling edge. DOWN takes **wake** back to HALT once `pwrdn_n` is high again, and never goes straight to an enabled state.

Top module: `clkstop_gate`

## Requirements
- R1: During reset and after it, `clk_gated` is 0 and `stopped` is 1. The synchronizer stages reset to the "stop requested" value, so a gate that is not free-running starts only after a released request has passed through the synchronizer.
- R2: A level on `stop_n` that is sampled at falling edge N takes effect on the enable at falling edge N+2 for the PCI-type group, and at falling edge N+3 for the CPU-type group. `stop_n` = 1 means run; `stop_n` = 0 means stop.
- R3: While stopped, `clk_gated` is held at 0. The enable changes only on falling edges, so every high phase of `clk_gated` is exactly one full source high phase.
- R4: After any restart, including the restart after power-down, the first high phase of `clk_gated` is full width and begins on the first rising edge after the enabling falling edge.
- R5: Once enabled, the gate delivers at least MIN_ON pulses before it may stop. MIN_ON defaults to 100 for the CPU-type group and 10 for the PCI-type group.
- R6: A stop request that takes effect before MIN_ON pulses have been delivered is held pending. With the request held, the gate delivers exactly MIN_ON pulses and then stops.
- R7: The free-running variant (FREE_RUN = 1) never stops in response to `stop_n`.
- R8: `pwrdn_n` = 0 at a falling edge forces the enable off from that edge onward, whatever `stop_n` is. Leaving power-down passes through HALT, so the output restarts no earlier than the second falling edge at which `pwrdn_n` is high.
- R9: `stopped` is 1 exactly when `clk_gated` is being held low by the gate, and 0 while pulses pass.
- R10: Power-down also stops the free-running variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock to be gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| pwrdn_n | input | 1 | Active-low global power-down |
| clk_gated | output | 1 | Gated output clock |
| stopped | output | 1 | 1 while the output is held low |

## Verification
The bench drives three instances side by side from the same stimulus: a CPU-type gate, a PCI-type gate and a free-running PCI-type gate. It compares each against a behavioural model, sampling once near the start and once near the end of every high phase and once in every low phase.

- **A single release followed by a single request** separates the two latencies, because the two groups must change state on different falling edges.
- **A release followed almost at once by a new request** separates the pending-stop logic from plain stopping: the exact pulse counts must come out as 100 and 10.
- **Power-down while `stop_n` toggles every cycle** shows whether power-down truly overrides the stop input, including on the free-running instance.
- **A stretch of random request toggling** exercises the transitions at unplanned boundaries.

Throughout, every high phase of the output is timed, so that a truncated or stretched pulse is caught.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Clock group selects latency and minimum enabled time.
    typedef enum logic {
        GRP_CPU = 1'b0,
        GRP_PCI = 1'b1
    } clk_grp_e;

    // Gate states; RUN and WARM both pass the clock.
    typedef enum logic [1:0] {
        ST_HALT = 2'b00,
        ST_WARM = 2'b01,
        ST_RUN  = 2'b11,
        ST_DOWN = 2'b10
    } gate_st_e;

    function automatic int min_on_of(clk_grp_e g);
        return (g == GRP_CPU) ? 100 : 10;
    endfunction

    // Falling-edge stages between the stop pin and the state machine.
    function automatic int sync_depth_of(clk_grp_e g);
        return (g == GRP_CPU) ? 3 : 2;
    endfunction

endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = DEPTH - 1;

    logic stage_q [DEPTH];

    // Chain of falling-edge flops; reset value 0 means "stop requested".
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(negedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= 1'b0;
                    else        stage_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(negedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= 1'b0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[LAST];

endmodule

// File: rtl/clkstop_mincnt.sv
module clkstop_mincnt #(
    parameter int MIN_ON = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_en,
    output logic min_met
);
    localparam int CAP = (MIN_ON > 0) ? MIN_ON - 1 : 0;
    localparam int CW  = (CAP > 0) ? $clog2(CAP + 1) : 1;

    logic [CW-1:0] cnt_q;

    // Counts pulses already delivered since the enable rose; saturates at CAP.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_en) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(CAP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign min_met = (cnt_q == CW'(CAP));

    AST_CNT_CAP: assert property (@(negedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CAP)) else $error("pulse counter beyond cap"); // R5

endmodule

// File: rtl/clkstop_fsm.sv
module clkstop_fsm
    import clkstop_pkg::*;
#(
    parameter bit FREE_RUN = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_run,
    input  logic pwrdn_n,
    input  logic min_met,
    output logic run_en,
    output logic stopped
);
    gate_st_e state_q, state_d;
    logic     go, halt_req;

    assign go       = FREE_RUN || req_run;
    assign halt_req = !FREE_RUN && !req_run;

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (go) state_d = ST_WARM;                       // start
            ST_WARM: if (min_met) state_d = halt_req ? ST_HALT : ST_RUN; // late stop / settle
            ST_RUN:  if (halt_req) state_d = ST_HALT;                 // stop
            ST_DOWN: state_d = ST_HALT;                               // wake
            default: state_d = ST_HALT;
        endcase
        if (!pwrdn_n) state_d = ST_DOWN;                              // power-down
    end

    // State register, falling edge only.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // Registered outputs so the enable is a single clean flop.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en  <= 1'b0;
            stopped <= 1'b1;
        end else begin
            run_en  <= (state_d == ST_WARM) || (state_d == ST_RUN);
            stopped <= !((state_d == ST_WARM) || (state_d == ST_RUN));
        end
    end

    AST_MIN_BEFORE_STOP: assert property (@(negedge clk) disable iff (!rst_n)
        $fell(run_en) |-> ($past(min_met) || !$past(pwrdn_n)))
        else $error("enable dropped before minimum pulses"); // R5

    AST_DOWN_FORCES_LOW: assert property (@(negedge clk) disable iff (!rst_n)
        !pwrdn_n |=> !run_en) else $error("enable high in power-down"); // R8

    AST_RESTART_VIA_HALT: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(run_en) |-> ($past(state_q) == ST_HALT))
        else $error("restart not from halt"); // R8

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate
    import clkstop_pkg::*;
#(
    parameter clk_grp_e GROUP      = GRP_CPU,
    parameter bit       FREE_RUN   = 1'b0,
    parameter int       MIN_ON     = min_on_of(GROUP),
    parameter int       SYNC_DEPTH = sync_depth_of(GROUP)
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic stop_n,
    input  logic pwrdn_n,
    output logic clk_gated,
    output logic stopped
);
    logic req_run;
    logic min_met;
    logic run_en;

    clkstop_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .async_in (stop_n),
        .sync_out (req_run)
    );

    clkstop_mincnt #(.MIN_ON(MIN_ON)) u_cnt (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .min_met (min_met)
    );

    clkstop_fsm #(.FREE_RUN(FREE_RUN)) u_fsm (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .req_run (req_run),
        .pwrdn_n (pwrdn_n),
        .min_met (min_met),
        .run_en  (run_en),
        .stopped (stopped)
    );

    // Enable only moves while clk_src is low, so this AND cannot chop a pulse.
    assign clk_gated = clk_src & run_en;

    always_comb begin
        if (rst_n && stopped) begin
            AST_GATED_LOW: assert (clk_gated == 1'b0) else $error("pulse while stopped"); // R3
        end
    end

    generate
        if (FREE_RUN) begin : g_free_chk
            AST_FREE_IGNORES_STOP: assert property (@(negedge clk_src) disable iff (!rst_n)
                $fell(run_en) |-> !$past(pwrdn_n)) else $error("free clock stopped"); // R7
        end
    endgenerate

endmodule

// File: tb/sim_clkstop_gate.sv
module sim_clkstop_gate;
    import clkstop_pkg::*;

    // 20-unit period: 50 MHz with 1 ns units.
    localparam int HALF = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_n = 1'b0;
    logic pwrdn_n = 1'b1;
    logic [2:0] gck;
    logic [2:0] stp;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit armed = 0;
    string cur_req = "R1";

    always #HALF clk = ~clk;

    clkstop_gate #(.GROUP(GRP_CPU)) u0 (
        .clk_src(clk), .rst_n(rst_n), .stop_n(stop_n), .pwrdn_n(pwrdn_n),
        .clk_gated(gck[0]), .stopped(stp[0]));
    clkstop_gate #(.GROUP(GRP_PCI)) u1 (
        .clk_src(clk), .rst_n(rst_n), .stop_n(stop_n), .pwrdn_n(pwrdn_n),
        .clk_gated(gck[1]), .stopped(stp[1]));
    clkstop_gate #(.GROUP(GRP_PCI), .FREE_RUN(1'b1)) u2 (
        .clk_src(clk), .rst_n(rst_n), .stop_n(stop_n), .pwrdn_n(pwrdn_n),
        .clk_gated(gck[2]), .stopped(stp[2]));

    task automatic chk(string tag, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0d exp %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    function automatic int lat_of(int i);
        return (i == 0) ? 3 : 2;
    endfunction
    function automatic int minon_of(int i);
        return (i == 0) ? 100 : 10;
    endfunction

    // Behavioural reference: history of sampled stop_n, enable and pulse count.
    bit       en_m  [3];
    int       cnt_m [3];
    bit       dn_m  [3];
    bit [3:0] hist  [3];

    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) begin
            bit run;
            bit fr;
            run = hist[i][lat_of(i)-1];
            fr  = (i == 2);
            if (!rst_n) begin
                en_m[i] = 0; cnt_m[i] = 0; dn_m[i] = 0; hist[i] = '0;
            end else begin
                if (!pwrdn_n) begin
                    en_m[i] = 0; dn_m[i] = 1;
                end else if (dn_m[i]) begin
                    dn_m[i] = 0;
                end else if (!en_m[i]) begin
                    if (run || fr) begin en_m[i] = 1; cnt_m[i] = 0; end
                end else if (!run && !fr && cnt_m[i] >= minon_of(i) - 1) begin
                    en_m[i] = 0;
                end else begin
                    cnt_m[i]++;
                end
                hist[i] = {hist[i][2:0], stop_n};
            end
        end
        armed = 1;
    end

    task automatic compare(bit high_phase);
        if (!armed || done) return;
        for (int i = 0; i < 3; i++) begin
            chk(cur_req, $sformatf("u%0d clk_gated", i), int'(gck[i]),
                high_phase ? int'(en_m[i]) : 0);
            chk("R9", $sformatf("u%0d stopped", i), int'(stp[i]), int'(!en_m[i]));
        end
    endtask

    always @(posedge clk) begin
        #1 compare(1'b1);
        #7 compare(1'b1);
    end
    always @(negedge clk) begin
        #5 compare(1'b0);
    end

    // Pulse counters and high-phase width checks.
    int pc [3];
    longint rise_t [3];
    always @(posedge gck[0]) begin pc[0]++; rise_t[0] = $time; end
    always @(posedge gck[1]) begin pc[1]++; rise_t[1] = $time; end
    always @(posedge gck[2]) begin pc[2]++; rise_t[2] = $time; end
    always @(negedge gck[0]) if (!done) chk("R4", "u0 high width", int'($time - rise_t[0]), HALF);
    always @(negedge gck[1]) if (!done) chk("R4", "u1 high width", int'($time - rise_t[1]), HALF);
    always @(negedge gck[2]) if (!done) chk("R3", "u2 high width", int'($time - rise_t[2]), HALF);

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic clear_pc();
        #2;
        for (int i = 0; i < 3; i++) pc[i] = 0;
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(2 * HALF * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state, stop requested
        cyc(4);
        rst_n = 1'b1;
        @(posedge clk); #3;
        chk("R1", "u0 stopped", int'(stp[0]), 1);
        chk("R1", "u1 stopped", int'(stp[1]), 1);
        chk("R1", "u0 clk_gated", int'(gck[0]), 0);
        cyc(6);

        // R2: release latency, PCI at N+2, CPU at N+3
        cur_req = "R2";
        stop_n = 1'b1;
        @(negedge clk); @(negedge clk); #5;
        chk("R2", "u1 stopped at N+1", int'(stp[1]), 1);
        @(negedge clk); #5;
        chk("R2", "u1 stopped at N+2", int'(stp[1]), 0);
        chk("R2", "u0 stopped at N+2", int'(stp[0]), 1);
        @(negedge clk); #5;
        chk("R2", "u0 stopped at N+3", int'(stp[0]), 0);

        // stop everything, then R5/R6: early request held pending
        cur_req = "R6";
        cyc(1); stop_n = 1'b0;
        cyc(150);
        stop_n = 1'b1;
        clear_pc();
        cyc(3); stop_n = 1'b0;
        cyc(200); #2;
        chk("R5", "u0 pulses with pending stop", pc[0], 100);
        chk("R6", "u1 pulses with pending stop", pc[1], 10);
        chk("R7", "u2 free-running pulses", pc[2], 203);

        // R3: held stop, no pulses
        cur_req = "R3";
        clear_pc();
        cyc(30); #2;
        chk("R3", "u0 pulses while stopped", pc[0], 0);
        chk("R3", "u1 pulses while stopped", pc[1], 0);

        // R8/R10: power-down overrides toggling stop_n
        stop_n = 1'b1;
        cyc(120);
        cur_req = "R8";
        pwrdn_n = 1'b0;
        clear_pc();
        for (int k = 0; k < 20; k++) begin
            stop_n = ~stop_n;
            cyc(1);
        end
        #2;
        chk("R8", "u0 pulses in power-down", pc[0], 0);
        chk("R8", "u1 pulses in power-down", pc[1], 0);
        chk("R10", "u2 pulses in power-down", pc[2], 0);
        chk("R10", "u2 stopped in power-down", int'(stp[2]), 1);

        // R4: restart after power-down, full pulses
        cur_req = "R4";
        stop_n = 1'b1;
        pwrdn_n = 1'b1;
        clear_pc();
        cyc(40); #2;
        chk("R4", "u1 restarted pulses", int'(pc[1] > 0), 1);

        // R2: random toggling with a short power-down
        cur_req = "R2";
        for (int k = 0; k < 40; k++) begin
            stop_n = ~stop_n;
            if (k == 20) pwrdn_n = 1'b0;
            if (k == 22) pwrdn_n = 1'b1;
            cyc(1 + ($urandom % 25));
        end
        stop_n = 1'b1;
        cyc(20);
        finish_run();
    end

endmodule